// File: doc/BRIEF.md
# Ethernet DMA FIFO Burst Requester

The block holds two word-wide FIFOs between a network MAC datapath and a system bus. One carries received words from the MAC towards memory, and the other carries words fetched from memory towards the MAC. Each FIFO raises a bus request when a burst can be moved without risk. The receive side asks for a four-word burst when enough data is waiting and some room is still left for the line. The transmit side asks for a four-word burst when four words fit. Near the end of a frame it asks for a shorter burst of two words or one word. To do this it uses the count of words still to fetch, which the DMA side supplies.

MAC-side transfers use valid/ready. On receive the MAC offers a word with `rx_in_valid`, and the block shows `rx_in_ready` while it has room. The MAC line cannot wait, so a word offered while ready is low is dropped and flagged as an overflow. On transmit the block shows `tx_out_valid` while a word is held, and the MAC takes it with `tx_out_ready`. A take while valid is low is flagged as an underflow. The bus side uses a grant pulse to start a burst. After that it moves one word per beat strobe, with the first counted beat on the cycle after the grant. Beats outside a burst still move data but are not counted. A flush empties both FIFOs and ends any burst. It does not clear the sticky flags, which clear only on reset.

Top module: `eth_dma_fifo_req`

## Requirements
- R1: Each FIFO holds DEPTH words (31 by default) in first-in first-out order. `rx_in_ready` is low exactly when the receive FIFO holds 31 words. `tx_out_valid` is high exactly when the transmit FIFO holds at least one word.
- R2: A push into a full FIFO, or a pop from an empty one, leaves the contents and the level unchanged. It sets the matching sticky flag (`*_overflow` or `*_underflow`), which stays set until reset.
- R3: Outside a burst, `rx_bus_req` is high exactly when the receive level lies between 4 and 28 inclusive, that is, at least four words present and at least three free.
- R4: Outside a burst, `tx_bus_req` is high exactly when `tx_remain` is nonzero and either at least four words are free, or at least two are free and `tx_remain` is 1 or 2.
- R5: Outside a burst, `tx_burst_len` is 4 when `tx_remain` is 4 or more, 2 when it is 2 or 3, and 1 otherwise. During a transmit burst it holds the value it had when the grant was taken. A receive burst is always four beats.
- R6: A grant taken while the request is high starts a burst. The request then stays high through the last counted beat, whatever the level. On the cycle after that beat the request follows the threshold again. A grant while the request is low, or during a burst, has no effect.
- R7: A cycle with `flush` high forces both requests low in that cycle. After it, both FIFOs are empty and no burst is active. The sticky flags keep their values.
- R8: A word pushed at one clock edge can be popped from the other side right after that edge. This is one cycle of latency, well inside a six-cycle budget.
- R9: After reset both FIFOs are empty, all flags are clear, and with `tx_remain` at zero both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty both FIFOs and end bursts |
| rx_in_valid | input | 1 | MAC offers a received word |
| rx_in_ready | output | 1 | Receive FIFO has room |
| rx_in_data | input | DATA_W | Received word |
| rx_bus_req | output | 1 | Receive burst request |
| rx_bus_gnt | input | 1 | Bus grants a receive burst |
| rx_bus_beat | input | 1 | Bus takes one receive word |
| rx_bus_data | output | DATA_W | Oldest receive word |
| rx_level | output | LVL_W | Receive FIFO fill level |
| rx_overflow | output | 1 | Sticky receive overflow |
| rx_underflow | output | 1 | Sticky receive underflow |
| tx_remain | input | REM_W | Words of the frame still to fetch |
| tx_bus_req | output | 1 | Transmit burst request |
| tx_bus_gnt | input | 1 | Bus grants a transmit burst |
| tx_bus_beat | input | 1 | Bus delivers one transmit word |
| tx_bus_data | input | DATA_W | Transmit word from the bus |
| tx_burst_len | output | LEN_W | Beats in the transmit burst |
| tx_out_valid | output | 1 | Transmit FIFO holds a word |
| tx_out_ready | input | 1 | MAC takes a transmit word |
| tx_out_data | output | DATA_W | Oldest transmit word |
| tx_level | output | LVL_W | Transmit FIFO fill level |
| tx_overflow | output | 1 | Sticky transmit overflow |
| tx_underflow | output | 1 | Sticky transmit underflow |

## Verification
On every cycle the assertions check several properties. The level never goes above the depth. A refused push or pop leaves the level unchanged, and the sticky flags never drop. A flush always yields an empty FIFO. A burst begins only after a granted request, and the request holds until the final beat. An idle receive request implies a level within the window, and an idle transmit burst length always fits the free space. Only the bench scenarios can show the exact threshold tables for every level and remaining count. They also show word ordering, the burst length held against a changing remaining count, and grants that are ignored.

// File: rtl/eth_dma_fifo_pkg.sv
package eth_dma_fifo_pkg;

  // receive: enough words to fill a burst and still some room for the line
  function automatic logic rx_rule(input int unsigned level, input int unsigned depth,
                                   input int unsigned burst, input int unsigned room);
    return (level >= burst) && ((depth - level) >= room);
  endfunction

  // transmit: full burst room, or short-burst room when the frame is nearly done
  function automatic logic tx_rule(input int unsigned level, input int unsigned depth,
                                   input int unsigned remain, input int unsigned burst,
                                   input int unsigned short_room);
    int unsigned free_w;
    free_w = depth - level;
    return (remain != 0) &&
           ((free_w >= burst) || ((free_w >= short_room) && (remain <= short_room)));
  endfunction

  function automatic int unsigned tx_len(input int unsigned remain, input int unsigned burst,
                                         input int unsigned short_room);
    if (remain >= burst)     return burst;
    if (remain >= short_room) return short_room;
    return 1;
  endfunction

endpackage

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 31,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     pop_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] cnt_q;
  logic             ovf_q, udf_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (cnt_q == LVL_W'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign do_push  = push && !full && !flush;
  assign do_pop   = pop && !empty && !flush;
  assign pop_data = mem[rd_ptr];
  assign level    = cnt_q;
  assign overflow  = ovf_q;
  assign underflow = udf_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + LVL_W'(1);
        2'b01:   cnt_q <= cnt_q - LVL_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (push && full)  ovf_q <= 1'b1;
      if (pop && empty)  udf_q <= 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (level == $past(level))); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R2
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R7

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl #(
  parameter int unsigned BURST = 4,
  localparam int unsigned LEN_W = $clog2(BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             thresh,
  input  logic [LEN_W-1:0] len_now,
  input  logic             gnt,
  input  logic             beat,
  output logic             req,
  output logic [LEN_W-1:0] len,
  output logic             busy
);

  logic             busy_q;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic             start, last;

  assign start = gnt && !busy_q && thresh && !flush;
  assign last  = busy_q && beat && (cnt_q == len_q - LEN_W'(1));
  assign req   = !flush && (busy_q || thresh);
  assign len   = busy_q ? len_q : len_now;
  assign busy  = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= len_now;
    end else if (busy_q && beat) begin
      if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(gnt && req)); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !flush) |=> (req || flush)); // R6
  AST_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !flush) |=> (len == $past(len))); // R5

endmodule

// File: rtl/eth_dma_fifo_req.sv
module eth_dma_fifo_req
  import eth_dma_fifo_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 31,
  parameter int unsigned REM_W   = 12,
  parameter int unsigned BURST   = 4,
  parameter int unsigned RX_ROOM = 3,
  parameter int unsigned SHORT   = 2,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1),
  localparam int unsigned LEN_W  = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_bus_req,
  input  logic              rx_bus_gnt,
  input  logic              rx_bus_beat,
  output logic [DATA_W-1:0] rx_bus_data,
  output logic [LVL_W-1:0]  rx_level,
  output logic              rx_overflow,
  output logic              rx_underflow,
  input  logic [REM_W-1:0]  tx_remain,
  output logic              tx_bus_req,
  input  logic              tx_bus_gnt,
  input  logic              tx_bus_beat,
  input  logic [DATA_W-1:0] tx_bus_data,
  output logic [LEN_W-1:0]  tx_burst_len,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic [LVL_W-1:0]  tx_level,
  output logic              tx_overflow,
  output logic              tx_underflow
);

  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             rx_thresh, tx_thresh, rx_busy, tx_busy;
  logic [LEN_W-1:0] tx_len_now, rx_len_unused_n;
  logic [LVL_W-1:0] tx_free;

  dma_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_in_valid), .push_data(rx_in_data),
    .pop(rx_bus_beat), .pop_data(rx_bus_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .overflow(rx_overflow), .underflow(rx_underflow)
  );

  dma_word_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(tx_bus_beat), .push_data(tx_bus_data),
    .pop(tx_out_ready), .pop_data(tx_out_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .overflow(tx_overflow), .underflow(tx_underflow)
  );

  assign rx_in_ready  = !rx_full;
  assign tx_out_valid = !tx_empty;
  assign tx_free      = LVL_W'(DEPTH) - tx_level;

  always_comb begin
    rx_thresh  = rx_rule(32'(rx_level), DEPTH, BURST, RX_ROOM);
    tx_thresh  = tx_rule(32'(tx_level), DEPTH, 32'(tx_remain), BURST, SHORT);
    tx_len_now = LEN_W'(tx_len(32'(tx_remain), BURST, SHORT));
  end

  dma_burst_ctrl #(.BURST(BURST)) u_rx_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .thresh(rx_thresh), .len_now(LEN_W'(BURST)),
    .gnt(rx_bus_gnt), .beat(rx_bus_beat),
    .req(rx_bus_req), .len(rx_len_unused_n), .busy(rx_busy)
  );

  dma_burst_ctrl #(.BURST(BURST)) u_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .thresh(tx_thresh), .len_now(tx_len_now),
    .gnt(tx_bus_gnt), .beat(tx_bus_beat),
    .req(tx_bus_req), .len(tx_burst_len), .busy(tx_busy)
  );

  AST_RX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bus_req && !rx_busy) |->
      (rx_level >= LVL_W'(BURST)) && (rx_level <= LVL_W'(DEPTH - RX_ROOM))); // R3
  AST_TX_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bus_req && !tx_busy) |-> (LVL_W'(tx_burst_len) <= tx_free)); // R5
  AST_RX_LEN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len_unused_n == LEN_W'(BURST)); // R5
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_ready |-> (rx_level < LVL_W'(DEPTH))); // R1

endmodule

// File: tb/eth_dma_fifo_req_test.sv
module eth_dma_fifo_req_test;

  localparam int DEPTH = 31;

  logic        clk = 1'b0;
  logic        rst_n, flush;
  logic        rx_in_valid, rx_in_ready;
  logic [31:0] rx_in_data, rx_bus_data;
  logic        rx_bus_req, rx_bus_gnt, rx_bus_beat;
  logic [4:0]  rx_level, tx_level;
  logic        rx_overflow, rx_underflow;
  logic [11:0] tx_remain;
  logic        tx_bus_req, tx_bus_gnt, tx_bus_beat;
  logic [31:0] tx_bus_data, tx_out_data;
  logic [2:0]  tx_burst_len;
  logic        tx_out_valid, tx_out_ready, tx_overflow, tx_underflow;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  eth_dma_fifo_req uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_bus_req(rx_bus_req), .rx_bus_gnt(rx_bus_gnt), .rx_bus_beat(rx_bus_beat),
    .rx_bus_data(rx_bus_data), .rx_level(rx_level),
    .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
    .tx_remain(tx_remain), .tx_bus_req(tx_bus_req), .tx_bus_gnt(tx_bus_gnt),
    .tx_bus_beat(tx_bus_beat), .tx_bus_data(tx_bus_data), .tx_burst_len(tx_burst_len),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_level(tx_level), .tx_overflow(tx_overflow), .tx_underflow(tx_underflow)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_rx_req(input int lvl);
    return (lvl >= 4) && (DEPTH - lvl >= 3);
  endfunction

  function automatic bit exp_tx_req(input int lvl, input int rem);
    int fr;
    fr = DEPTH - lvl;
    return (rem != 0) && ((fr >= 4) || ((fr >= 2) && (rem <= 2)));
  endfunction

  function automatic int exp_len(input int rem);
    return (rem >= 4) ? 4 : ((rem >= 2) ? 2 : 1);
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic rx_push(input logic [31:0] d);
    rx_in_valid = 1'b1; rx_in_data = d; tick; rx_in_valid = 1'b0;
  endtask

  task automatic rx_beat;
    rx_bus_beat = 1'b1; tick; rx_bus_beat = 1'b0;
  endtask

  task automatic tx_beat(input logic [31:0] d);
    tx_bus_beat = 1'b1; tx_bus_data = d; tick; tx_bus_beat = 1'b0;
  endtask

  task automatic tx_pop;
    tx_out_ready = 1'b1; tick; tx_out_ready = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    summary;
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0;
    rx_in_valid = 1'b0; rx_in_data = '0; rx_bus_gnt = 1'b0; rx_bus_beat = 1'b0;
    tx_remain = '0; tx_bus_gnt = 1'b0; tx_bus_beat = 1'b0; tx_bus_data = '0;
    tx_out_ready = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;

    // R9 reset state
    chk("R9", "rx_level", rx_level, 0);
    chk("R9", "tx_level", tx_level, 0);
    chk("R9", "rx_bus_req", rx_bus_req, 0);
    chk("R9", "tx_bus_req", tx_bus_req, 0);
    chk("R9", "flags", {rx_overflow, rx_underflow, tx_overflow, tx_underflow}, 0);
    chk("R9", "rx_in_ready", rx_in_ready, 1);
    chk("R9", "tx_out_valid", tx_out_valid, 0);

    // R1/R3 receive fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      rx_push(32'hA000_0000 + 32'(k - 1));
      chk("R1", "rx_level", rx_level, k);
      chk("R1", "rx_in_ready", rx_in_ready, (k < DEPTH) ? 1 : 0);
      chk("R3", "rx_bus_req", rx_bus_req, exp_rx_req(k));
    end
    rx_push(32'hDEAD_BEEF);
    chk("R2", "rx_overflow", rx_overflow, 1);
    chk("R2", "rx_level after refused push", rx_level, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R1", "rx order", rx_bus_data, 32'hA000_0000 + 32'(k));
      rx_beat;
    end
    chk("R1", "rx_level drained", rx_level, 0);
    rx_beat;
    chk("R2", "rx_underflow", rx_underflow, 1);
    chk("R2", "rx_level after refused pop", rx_level, 0);
    chk("R2", "rx_overflow sticky", rx_overflow, 1);

    // R8 one-cycle pass-through
    rx_push(32'h1234_5678);
    chk("R8", "rx_bus_data", rx_bus_data, 32'h1234_5678);
    chk("R8", "rx_level", rx_level, 1);
    rx_beat;

    // R6 receive burst hold
    for (int k = 0; k < 6; k++) rx_push(32'hB000_0000 + 32'(k));
    chk("R6", "req before grant", rx_bus_req, 1);
    rx_bus_gnt = 1'b1; tick; rx_bus_gnt = 1'b0;
    chk("R6", "req after grant", rx_bus_req, 1);
    for (int b = 1; b <= 3; b++) begin
      rx_beat;
      chk("R6", "req held mid-burst", rx_bus_req, 1);
    end
    chk("R6", "level mid-burst", rx_level, 3);
    rx_beat;
    chk("R6", "req after last beat", rx_bus_req, 0);
    rx_bus_gnt = 1'b1; tick; rx_bus_gnt = 1'b0;
    chk("R6", "grant while low", rx_bus_req, 0);
    rx_push(32'hC0); rx_push(32'hC1);
    chk("R6", "req at level 4", rx_bus_req, 1);
    rx_beat;
    chk("R6", "ignored grant started nothing", rx_bus_req, 0);
    repeat (3) rx_beat;
    chk("R6", "rx drained", rx_level, 0);

    // R4/R5 transmit sweep over level and remaining count
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int r = 0; r <= 5; r++) begin
        tx_remain = 12'(r);
        #1;
        chk("R4", "tx_bus_req", tx_bus_req, exp_tx_req(lvl, r));
        chk("R5", "tx_burst_len", tx_burst_len, exp_len(r));
      end
      tx_remain = '0;
      if (lvl < DEPTH) tx_beat(32'h5000_0000 + 32'(lvl));
    end
    tx_beat(32'hFFFF_FFFF);
    chk("R2", "tx_overflow", tx_overflow, 1);
    chk("R2", "tx_level after refused push", tx_level, DEPTH);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R1", "tx_out_valid", tx_out_valid, 1);
      chk("R1", "tx order", tx_out_data, 32'h5000_0000 + 32'(k));
      tx_pop;
    end
    chk("R1", "tx_out_valid empty", tx_out_valid, 0);
    tx_pop;
    chk("R2", "tx_underflow", tx_underflow, 1);
    chk("R2", "tx_level after refused pop", tx_level, 0);

    // R5 burst length held during a transmit burst
    tx_remain = 12'd3;
    #1;
    chk("R5", "short len", tx_burst_len, 2);
    chk("R4", "short req", tx_bus_req, 1);
    tx_bus_gnt = 1'b1; tick; tx_bus_gnt = 1'b0;
    tx_remain = 12'd5;
    #1;
    chk("R5", "len held", tx_burst_len, 2);
    tx_beat(32'h77);
    chk("R5", "len held beat1", tx_burst_len, 2);
    chk("R6", "tx req held", tx_bus_req, 1);
    tx_beat(32'h78);
    chk("R5", "len after burst", tx_burst_len, 4);
    chk("R1", "tx_level", tx_level, 2);

    // R7 flush
    for (int k = 0; k < 5; k++) rx_push(32'hE0 + 32'(k));
    rx_bus_gnt = 1'b1; tick; rx_bus_gnt = 1'b0;
    flush = 1'b1;
    #1;
    chk("R7", "rx req during flush", rx_bus_req, 0);
    chk("R7", "tx req during flush", tx_bus_req, 0);
    tick;
    flush = 1'b0;
    #1;
    chk("R7", "rx_level", rx_level, 0);
    chk("R7", "tx_level", tx_level, 0);
    chk("R7", "tx_out_valid", tx_out_valid, 0);
    chk("R7", "rx req after flush", rx_bus_req, 0);
    chk("R7", "flags kept", {rx_overflow, rx_underflow, tx_overflow, tx_underflow}, 4'hF);
    chk("R7", "tx req after flush", tx_bus_req, 1);

    summary;
    $finish;
  end

endmodule